// File: doc/BRIEF.md
# Four-Way Physically Tagged Cache Controller

This block controls a 16 KB, four-way set-associative data cache with 16-byte lines of four 32-bit words. The CPU side presents only the 12-bit page offset of its address, so the block reads the tags of the selected set while the page translator is still working. The translated 20-bit physical page number arrives later with a valid strobe, and the block compares it against the four stored physical tags.

Misses are handled one at a time over a simple word-wide memory port. A line is always filled completely, starting at word 0, before the request is answered. Loads that hit return data at once. Stores that hit change only the cache and mark the line dirty. A store that misses allocates the line, merges the new bytes, and then sends the merged word to memory, which leaves the line clean. A dirty victim is written back in full before its replacement is fetched. Victims are taken from invalid ways first. When all four ways are valid, a three-bit tree per set chooses the victim.

Top module: `vipt_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_ack` and `mem_req` are low, and the first access to any line is a miss. No memory request is raised while the controller is idle.
- R2: The set is `cpu_off[11:4]`, the word is `cpu_off[3:2]` and the tag is the 20-bit `xlat_ppn`. A request is not answered before `xlat_valid` has been seen high, and an access to the same offset with a different page number is a miss.
- R3: A read miss (no dirty victim) issues exactly four memory reads at byte address `{ppn, set, word, 2'b00}` for words 0, 1, 2 and 3 in that order. Only then is `cpu_ack` pulsed, with the requested data.
- R4: A read hit returns its data with `cpu_ack` one clock after `xlat_valid` is sampled, and no memory request is made.
- R5: A write hit updates the cached word, marks the line dirty and makes no memory request.
- R6: A write miss fills the line (four reads, ascending), merges the store, and then issues exactly one memory write of the merged word at its own word address before `cpu_ack`. The line is left clean, so a later eviction of it writes nothing back.
- R7: `cpu_size` encodes 0 = byte at lane `cpu_off[1:0]`, 1 = halfword at lane `cpu_off[1]`, 2 = full word. Reads return the selected field zero-extended at bit 0. Writes take the field from the low bits of `cpu_wdata` and leave the other bytes untouched.
- R8: An invalid way (lowest index first) is always replaced before a valid one. Otherwise a per-set pseudo-LRU tree picks the victim, so after four lines are filled into ways 0 to 3 in order, the next miss replaces the first of them, and a line touched since then stays resident.
- R9: When the victim is dirty, its four words are written to `{old tag, set, word, 2'b00}` in ascending order, carrying the modified data. This happens before the first fill read.
- R10: `mem_req`, `mem_we` and `mem_addr` stay stable from the rise of a request until `mem_ack`, and at most one miss is in progress.
- R11: `cpu_ack` is a single-cycle pulse, exactly one per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Request, held with its fields until `cpu_ack` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| cpu_off | input | 12 | Page-offset part of the address |
| cpu_wdata | input | 32 | Store data, field in low bits |
| cpu_ack | output | 1 | Completion pulse |
| cpu_rdata | output | 32 | Load result, valid with `cpu_ack` |
| xlat_valid | input | 1 | Translated page number is valid |
| xlat_ppn | input | 20 | Translated physical page number |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | 32 | Word-aligned physical byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory completion, one cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The bench delays the translation strobe by several cycles and checks that nothing is answered early. A design that compared tags against a stale page number would answer the load too soon, or with the wrong line. It fills one set completely and then forces a dirty eviction. A controller that wrote back too few words, wrote them after the fill or dropped the merged bytes leaves the wrong values in the bench memory, and that memory is read back on the next miss. Write misses are checked for the single write-through after the fill and for the clean state that follows; a design that marked the line dirty would later write back a clean victim. Sub-word stores and loads at several lanes expose errors in the byte lane placement.

// File: rtl/vcache_pkg.sv
// Shared types and byte-lane helpers for the physically tagged cache.
// Assumes a 32-bit word and little-endian byte lanes inside it.
package vcache_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WBACK,
        ST_FILL,
        ST_WTHRU
    } ctl_state_e;

    // Insert a byte, halfword or word into an existing word.
    function automatic logic [WORD_W-1:0] lane_merge(
        input logic [WORD_W-1:0] old_word,
        input logic [WORD_W-1:0] wd,
        input logic [1:0]        sz,
        input logic [1:0]        lo
    );
        logic [WORD_W-1:0] res;
        res = old_word;
        case (sz)
            2'd0:    res[{lo, 3'b000} +: 8]        = wd[7:0];
            2'd1:    res[{lo[1], 4'b0000} +: 16]   = wd[15:0];
            default: res                           = wd;
        endcase
        return res;
    endfunction

    // Pull a byte, halfword or word out of a word, zero-extended.
    function automatic logic [WORD_W-1:0] lane_extract(
        input logic [WORD_W-1:0] w,
        input logic [1:0]        sz,
        input logic [1:0]        lo
    );
        logic [WORD_W-1:0] res;
        res = '0;
        case (sz)
            2'd0:    res[7:0]  = w[{lo, 3'b000} +: 8];
            2'd1:    res[15:0] = w[{lo[1], 4'b0000} +: 16];
            default: res       = w;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/vcache_tag_store.sv
// Tag, valid and dirty state for every way of the cache.
// Reads are asynchronous at one set index. Install sets valid and clears
// dirty; set_dirty marks one line. Assumes no install and dirty mark to the
// same way and set in one cycle.
module vcache_tag_store #(
    parameter int WAYS  = 4,
    parameter int IDX_W = 8,
    parameter int TAG_W = 20
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [IDX_W-1:0]                rd_idx,
    output logic [WAYS-1:0][TAG_W-1:0]      rd_tag,
    output logic [WAYS-1:0]                 rd_valid,
    output logic [WAYS-1:0]                 rd_dirty,
    input  logic                            inst_en,
    input  logic [$clog2(WAYS)-1:0]         inst_way,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [TAG_W-1:0]                inst_tag,
    input  logic                            dirty_en,
    input  logic [$clog2(WAYS)-1:0]         dirty_way
);
    localparam int SETS  = 1 << IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic [TAG_W-1:0] tag_mem [SETS];
        logic [SETS-1:0]  vld;
        logic [SETS-1:0]  drt;

        // Record the physical tag of a newly installed line.
        always_ff @(posedge clk) begin
            if (inst_en && inst_way == WAY_W'(g))
                tag_mem[wr_idx] <= inst_tag;
        end

        // Maintain valid and dirty flags per line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld <= '0;
                drt <= '0;
            end else begin
                if (inst_en && inst_way == WAY_W'(g)) begin
                    vld[wr_idx] <= 1'b1;
                    drt[wr_idx] <= 1'b0;
                end
                if (dirty_en && dirty_way == WAY_W'(g))
                    drt[wr_idx] <= 1'b1;
            end
        end

        assign rd_tag[g]   = tag_mem[rd_idx];
        assign rd_valid[g] = vld[rd_idx];
        assign rd_dirty[g] = drt[rd_idx];
    end

endmodule

// File: rtl/vcache_data_store.sv
// Line data for every way, one word per entry addressed by {set, word}.
// Asynchronous read of the same word in all ways; one word write per cycle.
module vcache_data_store #(
    parameter int WAYS   = 4,
    parameter int IDX_W  = 8,
    parameter int WSEL_W = 2,
    parameter int DW     = 32
) (
    input  logic                        clk,
    input  logic [IDX_W-1:0]            rd_idx,
    input  logic [WSEL_W-1:0]           rd_word,
    output logic [WAYS-1:0][DW-1:0]     rd_data,
    input  logic                        wr_en,
    input  logic [$clog2(WAYS)-1:0]     wr_way,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [WSEL_W-1:0]           wr_word,
    input  logic [DW-1:0]               wr_data
);
    localparam int DEPTH = 1 << (IDX_W + WSEL_W);
    localparam int WAY_W = $clog2(WAYS);

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic [DW-1:0] ram [DEPTH];

        // Write one word into this way when selected.
        always_ff @(posedge clk) begin
            if (wr_en && wr_way == WAY_W'(g))
                ram[{wr_idx, wr_word}] <= wr_data;
        end

        assign rd_data[g] = ram[{rd_idx, rd_word}];
    end

endmodule

// File: rtl/vcache_plru.sv
// Three-bit tree pseudo-LRU per set for a four-way cache.
// top bit names the half holding the victim, lo/hi bits the way within that
// half. A touch points every bit on its path away from the touched way.
// Assumes exactly four ways.
module vcache_plru #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       victim,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [1:0]       touch_way
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0] b_top;
    logic [SETS-1:0] b_lo;
    logic [SETS-1:0] b_hi;

    // Update the tree of the touched set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_top <= '0;
            b_lo  <= '0;
            b_hi  <= '0;
        end else if (touch_en) begin
            b_top[touch_idx] <= ~touch_way[1];
            if (touch_way[1])
                b_hi[touch_idx] <= ~touch_way[0];
            else
                b_lo[touch_idx] <= ~touch_way[0];
        end
    end

    // Follow the tree of the read set to its victim.
    always_comb begin
        victim[1] = b_top[rd_idx];
        victim[0] = b_top[rd_idx] ? b_hi[rd_idx] : b_lo[rd_idx];
    end

endmodule

// File: rtl/vipt_cache_ctrl.sv
// Controller of a set-associative cache indexed by page-offset bits and
// tagged with the translated physical page number. One miss at a time:
// dirty victim write-back, ascending line fill, then a replay of the lookup
// that answers the request. Write hits stay in the cache; write misses
// allocate and then write the merged word through.
// Assumes cpu_* fields are held until cpu_ack and xlat_ppn is stable while
// xlat_valid is high; the memory side holds mem_ack high for one cycle.
module vipt_cache_ctrl
    import vcache_pkg::*;
#(
    parameter int PA_W       = 32,
    parameter int PAGE_OFF_W = 12,
    parameter int WAYS       = 4,
    parameter int LINE_WORDS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_req,
    input  logic                         cpu_we,
    input  logic [1:0]                   cpu_size,
    input  logic [PAGE_OFF_W-1:0]        cpu_off,
    input  logic [WORD_W-1:0]            cpu_wdata,
    output logic                         cpu_ack,
    output logic [WORD_W-1:0]            cpu_rdata,
    input  logic                         xlat_valid,
    input  logic [PA_W-PAGE_OFF_W-1:0]   xlat_ppn,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [PA_W-1:0]              mem_addr,
    output logic [WORD_W-1:0]            mem_wdata,
    input  logic                         mem_ack,
    input  logic [WORD_W-1:0]            mem_rdata
);
    localparam int BSEL_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int IDX_W  = PAGE_OFF_W - WSEL_W - BSEL_W;
    localparam int TAG_W  = PA_W - PAGE_OFF_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(LINE_WORDS - 1);

    ctl_state_e          state;
    logic [IDX_W-1:0]    idx_q;
    logic [WSEL_W-1:0]   word_q;
    logic [BSEL_W-1:0]   lo_q;
    logic [1:0]          size_q;
    logic                we_q;
    logic [WORD_W-1:0]   wdata_q;
    logic [TAG_W-1:0]    ppn_q;
    logic                ppn_held;
    logic                miss_q;
    logic [WAY_W-1:0]    victim_q;
    logic [TAG_W-1:0]    vtag_q;
    logic [WSEL_W-1:0]   cnt;
    logic [WORD_W-1:0]   merged_q;

    logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
    logic [WAYS-1:0]             rd_valid;
    logic [WAYS-1:0]             rd_dirty;
    logic [WAYS-1:0][WORD_W-1:0] rd_data;
    logic [WSEL_W-1:0]           rd_word;
    logic [1:0]                  plru_victim;

    logic [TAG_W-1:0]    look_ppn;
    logic                look_go;
    logic                hit;
    logic [WAY_W-1:0]    hit_way;
    logic                any_inv;
    logic [WAY_W-1:0]    inv_way;
    logic [WAY_W-1:0]    victim;
    logic [WORD_W-1:0]   hit_word;
    logic [WORD_W-1:0]   merged;
    logic                fill_beat;

    logic                dwr_en;
    logic [WAY_W-1:0]    dwr_way;
    logic [WSEL_W-1:0]   dwr_word;
    logic [WORD_W-1:0]   dwr_data;

    // Page number used for the compare: held after a fill, live otherwise.
    assign look_ppn  = ppn_held ? ppn_q : xlat_ppn;
    assign look_go   = (state == ST_LOOKUP) && (ppn_held || xlat_valid);
    assign fill_beat = (state == ST_FILL) && mem_ack;
    assign rd_word   = (state == ST_WBACK) ? cnt : word_q;
    assign hit_word  = rd_data[hit_way];
    assign merged    = lane_merge(hit_word, wdata_q, size_q, lo_q);
    assign victim    = any_inv ? inv_way : WAY_W'(plru_victim);

    // Compare the four physical tags and find the lowest invalid way.
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (rd_valid[w] && rd_tag[w] == look_ppn) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
        any_inv = 1'b0;
        inv_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!rd_valid[w]) begin
                any_inv = 1'b1;
                inv_way = WAY_W'(w);
            end
        end
    end

    // Steer the single data write port between fill beats and store hits.
    always_comb begin
        dwr_en   = fill_beat || (look_go && hit && we_q);
        dwr_way  = (state == ST_FILL) ? victim_q  : hit_way;
        dwr_word = (state == ST_FILL) ? cnt       : word_q;
        dwr_data = (state == ST_FILL) ? mem_rdata : merged;
    end

    // Drive the memory port from the current miss-handling state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {vtag_q, idx_q, cnt, {BSEL_W{1'b0}}};
                mem_wdata = rd_data[victim_q];
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {ppn_q, idx_q, cnt, {BSEL_W{1'b0}}};
            end
            ST_WTHRU: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {ppn_q, idx_q, word_q, {BSEL_W{1'b0}}};
                mem_wdata = merged_q;
            end
            default: ;
        endcase
    end

    // Request sequencing: capture, lookup, write-back, fill, write-through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cpu_ack   <= 1'b0;
            cpu_rdata <= '0;
            idx_q     <= '0;
            word_q    <= '0;
            lo_q      <= '0;
            size_q    <= '0;
            we_q      <= 1'b0;
            wdata_q   <= '0;
            ppn_q     <= '0;
            ppn_held  <= 1'b0;
            miss_q    <= 1'b0;
            victim_q  <= '0;
            vtag_q    <= '0;
            cnt       <= '0;
            merged_q  <= '0;
        end else begin
            cpu_ack <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cpu_req) begin
                        idx_q    <= cpu_off[PAGE_OFF_W-1 -: IDX_W];
                        word_q   <= cpu_off[BSEL_W +: WSEL_W];
                        lo_q     <= cpu_off[BSEL_W-1:0];
                        size_q   <= cpu_size;
                        we_q     <= cpu_we;
                        wdata_q  <= cpu_wdata;
                        ppn_held <= 1'b0;
                        miss_q   <= 1'b0;
                        state    <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (look_go) begin
                        if (hit) begin
                            if (!we_q) begin
                                cpu_rdata <= lane_extract(hit_word, size_q, lo_q);
                                cpu_ack   <= 1'b1;
                                state     <= ST_IDLE;
                            end else if (miss_q) begin
                                merged_q <= merged;
                                state    <= ST_WTHRU;
                            end else begin
                                cpu_ack <= 1'b1;
                                state   <= ST_IDLE;
                            end
                        end else begin
                            ppn_q    <= look_ppn;
                            ppn_held <= 1'b1;
                            victim_q <= victim;
                            vtag_q   <= rd_tag[victim];
                            cnt      <= '0;
                            state    <= (rd_valid[victim] && rd_dirty[victim])
                                        ? ST_WBACK : ST_FILL;
                        end
                    end
                end
                ST_WBACK: begin
                    if (mem_ack) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_WORD)
                            state <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_WORD) begin
                            miss_q <= 1'b1;
                            state  <= ST_LOOKUP;
                        end
                    end
                end
                ST_WTHRU: begin
                    if (mem_ack) begin
                        cpu_ack <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    vcache_tag_store #(
        .WAYS  (WAYS),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (idx_q),
        .rd_tag    (rd_tag),
        .rd_valid  (rd_valid),
        .rd_dirty  (rd_dirty),
        .inst_en   (fill_beat && cnt == LAST_WORD),
        .inst_way  (victim_q),
        .wr_idx    (idx_q),
        .inst_tag  (ppn_q),
        .dirty_en  (look_go && hit && we_q && !miss_q),
        .dirty_way (hit_way)
    );

    vcache_data_store #(
        .WAYS   (WAYS),
        .IDX_W  (IDX_W),
        .WSEL_W (WSEL_W),
        .DW     (WORD_W)
    ) u_data (
        .clk     (clk),
        .rd_idx  (idx_q),
        .rd_word (rd_word),
        .rd_data (rd_data),
        .wr_en   (dwr_en),
        .wr_way  (dwr_way),
        .wr_idx  (idx_q),
        .wr_word (dwr_word),
        .wr_data (dwr_data)
    );

    vcache_plru #(
        .IDX_W (IDX_W)
    ) u_plru (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (idx_q),
        .victim    (plru_victim),
        .touch_en  (look_go && hit),
        .touch_idx (idx_q),
        .touch_way (2'(hit_way))
    );

endmodule

// File: rtl/vipt_cache_ctrl_chk.sv
// Protocol and sequencing properties of the cache controller, attached by bind.
// Assumes the default line of four words (word select in address bits 3:2).
module vipt_cache_ctrl_chk
    import vcache_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input ctl_state_e  state,
    input logic        cpu_ack,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !mem_req);

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R11
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    // R3
    fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && mem_ack && mem_addr[3:2] != 2'd3)
        |=> (state == ST_FILL && mem_addr[3:2] == $past(mem_addr[3:2]) + 2'd1));

    // R9
    wb_to_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WBACK && mem_ack && mem_addr[3:2] == 2'd3)
        |=> (state == ST_FILL && !mem_we && mem_addr[3:2] == 2'd0));

endmodule

bind vipt_cache_ctrl vipt_cache_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .cpu_ack  (cpu_ack),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr)
);

// File: tb/vipt_cache_ctrl_bench.sv
// Scoreboard bench: run_op pushes the expected response, a negedge monitor
// pops it on cpu_ack, and a memory responder logs every memory transfer.
module vipt_cache_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [11:0] cpu_off = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        xlat_valid = 1'b0;
    logic [19:0] xlat_ppn = '0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    bit          sb_rd  [$];
    logic [31:0] sb_dat [$];
    string       sb_rq  [$];
    bit          log_we   [$];
    logic [31:0] log_addr [$];

    logic [31:0] mem_store  [logic [31:0]];
    logic [31:0] arch_store [logic [31:0]];

    always #5 clk = ~clk;

    vipt_cache_ctrl u_vipt_cache_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
        .cpu_off(cpu_off), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .xlat_valid(xlat_valid), .xlat_ppn(xlat_ppn),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] seed_val(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
    endfunction

    function automatic logic [31:0] mem_get(input logic [31:0] a);
        return mem_store.exists(a) ? mem_store[a] : seed_val(a);
    endfunction

    function automatic logic [31:0] arch_get(input logic [31:0] a);
        return arch_store.exists(a) ? arch_store[a] : seed_val(a);
    endfunction

    function automatic int lane_shift(input logic [1:0] sz, input logic [1:0] lo);
        if (sz == 2'd0) return 8 * int'(lo);
        if (sz == 2'd1) return lo[1] ? 16 : 0;
        return 0;
    endfunction

    function automatic logic [31:0] lane_mask(input logic [1:0] sz);
        if (sz == 2'd0) return 32'h0000_00FF;
        if (sz == 2'd1) return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [11:0] off_of(input int idx, input int w, input int b);
        return {8'(idx), 2'(w), 2'(b)};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Memory model: one-cycle acknowledge, logs each transfer.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            log_we.push_back(mem_we);
            log_addr.push_back(mem_addr);
            if (mem_we) mem_store[mem_addr] = mem_wdata;
            else        mem_rdata <= mem_get(mem_addr);
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // Monitor: pop one expectation for every completion pulse.
    always @(negedge clk) begin
        if (rst_n && cpu_ack) begin
            if (sb_rd.size() == 0) begin
                chk(1'b0, "R11", "unexpected cpu_ack", 32'd1, 32'd0);
            end else begin
                bit          e_rd;
                logic [31:0] e_dat;
                string       e_rq;
                e_rd  = sb_rd.pop_front();
                e_dat = sb_dat.pop_front();
                e_rq  = sb_rq.pop_front();
                if (e_rd)
                    chk(cpu_rdata == e_dat, e_rq, "load data", cpu_rdata, e_dat);
            end
        end
    end

    // Driver: issue one access and check its memory traffic.
    task automatic run_op(input bit we, input logic [19:0] ppn, input logic [11:0] off,
                          input logic [1:0] sz, input logic [31:0] wd, input int xdelay,
                          input bit ex_wb, input logic [19:0] wb_ppn,
                          input bit ex_fill, input bit ex_wt, input string rq);
        logic [31:0] wa;
        logic [31:0] old;
        logic [31:0] msk;
        bit          exp_we   [$];
        logic [31:0] exp_addr [$];
        bit          early;
        bit          seq_ok;
        int          sh;
        int          tmo;
        wa  = {ppn, off[11:2], 2'b00};
        old = arch_get(wa);
        sh  = lane_shift(sz, off[1:0]);
        msk = lane_mask(sz);
        sb_rd.push_back(!we);
        sb_dat.push_back((old >> sh) & msk);
        sb_rq.push_back(rq);
        if (we) arch_store[wa] = (old & ~(msk << sh)) | ((wd & msk) << sh);
        if (ex_wb)
            for (int w = 0; w < 4; w++) begin
                exp_we.push_back(1'b1);
                exp_addr.push_back({wb_ppn, off[11:4], 2'(w), 2'b00});
            end
        if (ex_fill)
            for (int w = 0; w < 4; w++) begin
                exp_we.push_back(1'b0);
                exp_addr.push_back({ppn, off[11:4], 2'(w), 2'b00});
            end
        if (ex_wt) begin
            exp_we.push_back(1'b1);
            exp_addr.push_back(wa);
        end
        log_we.delete();
        log_addr.delete();
        @(negedge clk);
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_off   = off;
        cpu_size  = sz;
        cpu_wdata = wd;
        early = 1'b0;
        for (int d = 0; d < xdelay; d++) begin
            @(negedge clk);
            if (cpu_ack || mem_req) early = 1'b1;
        end
        if (xdelay > 0)
            chk(!early, "R2", "activity before translation", 32'(early), 32'd0);
        xlat_valid = 1'b1;
        xlat_ppn   = ppn;
        tmo = 0;
        do begin
            @(negedge clk);
            tmo++;
        end while (!cpu_ack && tmo < 300);
        if (!cpu_ack) chk(1'b0, rq, "no completion", 32'd0, 32'd1);
        cpu_req    = 1'b0;
        xlat_valid = 1'b0;
        seq_ok = (log_we.size() == exp_we.size());
        if (seq_ok)
            for (int i = 0; i < exp_we.size(); i++)
                if (log_we[i] != exp_we[i] || log_addr[i] != exp_addr[i]) seq_ok = 1'b0;
        chk(seq_ok, rq, "memory sequence length",
            32'(log_we.size()), 32'(exp_we.size()));
    endtask

    localparam logic [19:0] PA = 20'h00010, PB = 20'h00020, PC = 20'h00030,
                            PD = 20'h00040, PE = 20'h00050, PF = 20'h00077,
                            PG = 20'h00088, PK = 20'h000A1, PL = 20'h000A2,
                            PM = 20'h000A3, PN = 20'h000A4, PO = 20'h000A5;

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cpu_ack == 1'b0 && mem_req == 1'b0, "R1", "reset outputs",
            {30'd0, cpu_ack, mem_req}, 32'd0);
        // R1 R3 first access misses, delayed translation (R2)
        run_op(0, PA, off_of(5, 0, 0), 2'd2, 0, 3, 0, 0, 1, 0, "R3");
        // R4 R7 byte load hit
        run_op(0, PA, off_of(5, 2, 1), 2'd0, 0, 0, 0, 0, 0, 0, "R4");
        // R5 R7 byte store hit, no memory write
        run_op(1, PA, off_of(5, 1, 2), 2'd0, 32'h7777_77CD, 2, 0, 0, 0, 0, "R5");
        run_op(0, PA, off_of(5, 1, 0), 2'd2, 0, 0, 0, 0, 0, 0, "R5");
        // R7 halfword store in upper lane, then halfword load
        run_op(1, PA, off_of(5, 3, 2), 2'd1, 32'h1234_BEEF, 0, 0, 0, 0, 0, "R7");
        run_op(0, PA, off_of(5, 3, 2), 2'd1, 0, 1, 0, 0, 0, 0, "R7");
        // R2 R8 same offset, other pages: fill invalid ways, no eviction
        run_op(0, PB, off_of(5, 0, 0), 2'd2, 0, 0, 0, 0, 1, 0, "R8");
        run_op(0, PC, off_of(5, 3, 0), 2'd2, 0, 0, 0, 0, 1, 0, "R8");
        run_op(0, PD, off_of(5, 2, 0), 2'd1, 0, 0, 0, 0, 1, 0, "R8");
        // R9 oldest line is dirty: write back then fill
        run_op(0, PE, off_of(5, 1, 0), 2'd2, 0, 0, 1, PA, 1, 0, "R9");
        chk(mem_get({PA, off_of(5, 1, 0)}) == arch_get({PA, off_of(5, 1, 0)}), "R9",
            "written-back word 1", mem_get({PA, off_of(5, 1, 0)}),
            arch_get({PA, off_of(5, 1, 0)}));
        chk(mem_get({PA, off_of(5, 3, 0)}) == arch_get({PA, off_of(5, 3, 0)}), "R9",
            "written-back word 3", mem_get({PA, off_of(5, 3, 0)}),
            arch_get({PA, off_of(5, 3, 0)}));
        // R8 recently used line stays resident
        run_op(0, PD, off_of(5, 0, 0), 2'd2, 0, 0, 0, 0, 0, 0, "R8");
        // R9 evicted line comes back with its modified data
        run_op(0, PA, off_of(5, 1, 0), 2'd2, 0, 0, 0, 0, 1, 0, "R9");
        // R6 store miss: fill then one write-through
        run_op(1, PF, off_of(9, 2, 0), 2'd2, 32'h1234_5678, 0, 0, 0, 1, 1, "R6");
        chk(mem_get({PF, off_of(9, 2, 0)}) == 32'h1234_5678, "R6", "write-through value",
            mem_get({PF, off_of(9, 2, 0)}), 32'h1234_5678);
        run_op(0, PF, off_of(9, 2, 0), 2'd2, 0, 0, 0, 0, 0, 0, "R6");
        // R6 R7 halfword store miss in lane 0
        run_op(1, PG, off_of(9, 0, 0), 2'd1, 32'hFFFF_A55A, 0, 0, 0, 1, 1, "R6");
        run_op(0, PG, off_of(9, 0, 0), 2'd2, 0, 0, 0, 0, 0, 0, "R7");
        // R5 store hit after allocation: memory keeps the older value
        run_op(1, PF, off_of(9, 2, 3), 2'd0, 32'h0000_0099, 0, 0, 0, 0, 0, "R5");
        chk(mem_get({PF, off_of(9, 2, 0)}) == 32'h1234_5678, "R5", "memory untouched",
            mem_get({PF, off_of(9, 2, 0)}), 32'h1234_5678);
        run_op(0, PF, off_of(9, 2, 3), 2'd0, 0, 0, 0, 0, 0, 0, "R5");
        // R6 line allocated by a store miss is clean when evicted
        run_op(1, PK, off_of(12, 1, 0), 2'd2, 32'hCAFE_F00D, 0, 0, 0, 1, 1, "R6");
        run_op(0, PL, off_of(12, 0, 0), 2'd2, 0, 0, 0, 0, 1, 0, "R8");
        run_op(0, PM, off_of(12, 0, 0), 2'd2, 0, 0, 0, 0, 1, 0, "R8");
        run_op(0, PN, off_of(12, 0, 0), 2'd2, 0, 0, 0, 0, 1, 0, "R8");
        run_op(0, PO, off_of(12, 2, 0), 2'd2, 0, 0, 0, 0, 1, 0, "R6");
        // R8 the replaced line now misses
        run_op(0, PK, off_of(12, 1, 0), 2'd2, 0, 0, 0, 0, 1, 0, "R8");
        repeat (4) @(negedge clk);
        chk(sb_rd.size() == 0, "R11", "completions outstanding",
            32'(sb_rd.size()), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R11", "watchdog expired", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule